// File: doc/BRIEF.md
# Four-Wide Instruction Group Dispatcher

This block sits behind the decoder. It looks at the four oldest decoded instructions in the instruction buffer. Each instruction carries a 4-bit scheduling class. In every cycle the block works out, purely in program order, how many of those instructions form the next issue group. It reports that count and the execution unit each grouped lane goes to. The buffer pops `grp_size` entries on the next rising edge. Operand dependencies, register files and the execution units themselves are outside this block.

The grouping rules come from the shape of the machine:
- four issue lanes in total, with integer and memory work confined to the first three;
- two integer ALUs, of which ALU0 alone can shift and ALU1 alone can set condition codes;
- one load/store port;
- one branch unit;
- one port each for FP multiply and FP add.

Some classes must issue alone. Jump-and-link also occupies the load/store port and closes the group.

A small state machine tracks two time-based conditions:
- **Bubbles.** Long-latency operations are followed by bubble cycles in which no group forms.
- **FP-compare window.** For a short time after an FP compare, FP compare-sensitive instructions are held back.

The machine has three states:
- `ST_RUN`: normal grouping.
- `ST_FWIN`: the FP-compare window is open.
- `ST_STALL`: bubble cycles.

It has these transitions:
- `RUN/FWIN -> STALL`: a bubble-producing class issues. The counter is loaded with that class's bubble count.
- `RUN/FWIN -> FWIN`: an FP compare issues. The counter is loaded with the window length.
- `FWIN -> FWIN`: the counter counts down.
- `FWIN -> RUN`: the window has expired.
- `STALL -> STALL`: the counter counts down.
- `STALL -> RUN`: the last bubble has passed.
- Any state goes to `RUN` on reset.

Top module: `group_dispatch4`

## Requirements
- R1: Class codes are: 0 integer-any, 1 integer-pipe-0 (shift), 2 integer-pipe-1 (cc-setting), 3 load, 4 store, 5 control transfer, 6 FP multiply, 7 FP add, 8 single-issue, 9 jump-and-link, 10 64-bit divide, 11 64-bit multiply, 12 cc-register write, 13 cc-register read, 14 FP compare, 15 FP compare-sensitive.
  - Lane i of `head_cls` occupies bits [4i+3:4i]. Lanes are taken strictly in order.
  - An invalid lane, or the first lane that breaks a rule, ends the group, and no later lane joins it.
  - `grp_size` equals the number of lanes taken (0 to 4).
- R2: At most 4 instructions form a group. Integer, load, store and jump-and-link classes (codes 0-4 and 9) may take only group positions 0-2. Position 3 accepts only codes 5, 6, 7, 14 and 15.
- R3: A group holds at most one instruction of the load, store or jump-and-link classes.
- R4: A group holds at most one control transfer, at most one FP multiply, and at most one FP-add-port instruction. Codes 7, 14 and 15 all use the FP-add port.
- R5: A group holds at most 2 integer ALU instructions (codes 0-2). It holds at most one of code 1 and at most one of code 2.
- R6: `lane_unit` gives 3 bits per lane at [3i+2:3i]. The unit codes are: 0 none, 1 ALU0, 2 ALU1, 3 load/store, 4 branch, 5 FP multiply, 6 FP add, 7 jump-and-link via the load/store port. Lanes not in the group read 0.
  - Code 1 goes to ALU0 and code 2 goes to ALU1.
  - An integer-any instruction takes the ALU that the dedicated instruction in its group leaves free. If there is no dedicated instruction, the first integer-any takes ALU0 and the second takes ALU1.
  - Single-issue classes go to ALU0.
- R7: Codes 8, 10, 11, 12 and 13 issue only at group position 0 and form a group of size 1.
- R8: Jump-and-link (code 9) ends the group: no later lane joins it.
- R9: After a group containing a 64-bit divide, `grp_size` is 0 for exactly 68 cycles. The count is 19 for a 64-bit multiply and 4 for a cc-register write.
- R10: A cc-register read blocks issue for 5 cycles including its own issue cycle, so 4 cycles of `grp_size` 0 follow it.
- R11: For the 2 cycles after an FP compare issues, code 15 cannot join a group. Other classes are unaffected in those cycles.
- R12: Reset, asserted asynchronously at any time, returns the block to `ST_RUN` with no pending bubbles or window. Grouping is then governed by R1-R8 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld | input | 4 | Valid bit per buffer head lane |
| head_cls | input | 16 | Scheduling class per lane, 4 bits each |
| grp_size | output | 3 | Number of lanes forming this cycle's group |
| lane_unit | output | 12 | Execution unit per lane, 3 bits each |

## Verification
`grp_size` and `lane_unit` are combinational from the lanes and the current state, so they are due in the same cycle the lanes are presented. The bench drives each stimulus on the falling edge and samples 1 ns later, before the next rising edge commits anything. Bubbles and the compare window begin on the cycle after the issuing edge. The bench therefore counts zero-size cycles, each one sampled after its falling edge, from the cycle that follows the issuing group until a nonzero size returns. It compares that count with 68, 19, 4 and 4, and checks the two blocked window cycles one at a time.

// File: rtl/gdisp_pkg.sv
package gdisp_pkg;

    typedef enum logic [3:0] {
        C_INT_ANY = 4'd0,
        C_INT_P0  = 4'd1,
        C_INT_P1  = 4'd2,
        C_LOAD    = 4'd3,
        C_STORE   = 4'd4,
        C_CTI     = 4'd5,
        C_FPM     = 4'd6,
        C_FPA     = 4'd7,
        C_SINGLE  = 4'd8,
        C_JLINK   = 4'd9,
        C_DIV     = 4'd10,
        C_MUL     = 4'd11,
        C_CCR_WR  = 4'd12,
        C_CCR_RD  = 4'd13,
        C_FCMP    = 4'd14,
        C_FSENS   = 4'd15
    } iclass_e;

    typedef enum logic [2:0] {
        U_NONE = 3'd0,
        U_ALU0 = 3'd1,
        U_ALU1 = 3'd2,
        U_LSU  = 3'd3,
        U_BRU  = 3'd4,
        U_FPM  = 3'd5,
        U_FPA  = 3'd6,
        U_JLS  = 3'd7
    } unit_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FWIN  = 2'd1,
        ST_STALL = 2'd2
    } disp_state_e;

    function automatic logic is_alu(iclass_e c);
        return c inside {C_INT_ANY, C_INT_P0, C_INT_P1};
    endfunction

    function automatic logic is_lsu(iclass_e c);
        return c inside {C_LOAD, C_STORE, C_JLINK};
    endfunction

    function automatic logic is_single(iclass_e c);
        return c inside {C_SINGLE, C_DIV, C_MUL, C_CCR_WR, C_CCR_RD};
    endfunction

    function automatic logic is_fpa(iclass_e c);
        return c inside {C_FPA, C_FCMP, C_FSENS};
    endfunction

    function automatic logic ends_group(iclass_e c);
        return is_single(c) || (c == C_JLINK);
    endfunction

endpackage

// File: rtl/grp_former.sv
module grp_former
    import gdisp_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ALU_MAX    = 2,
    parameter int INTMEM_MAX = 3,
    parameter int SZW        = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   vld,
    input  logic [4*LANES-1:0] cls,
    input  logic               issue_ok,
    input  logic               fsens_block,
    output logic [LANES-1:0]   accept,
    output logic [SZW-1:0]     size,
    output logic               fcmp_issued
);

    always_comb begin
        int n, alu_n, mem_n, p0_n, p1_n, ls_n, cti_n, fpm_n, fpa_n;
        logic open, ok, fc;
        iclass_e c;
        n = 0; alu_n = 0; mem_n = 0; p0_n = 0; p1_n = 0;
        ls_n = 0; cti_n = 0; fpm_n = 0; fpa_n = 0;
        open = issue_ok;
        fc = 1'b0;
        accept = '0;
        for (int i = 0; i < LANES; i++) begin
            c  = iclass_e'(cls[4*i +: 4]);
            ok = open && vld[i];
            if (is_single(c) && n != 0)                             ok = 1'b0;
            if ((is_alu(c) || is_lsu(c)) && n == LANES - 1)         ok = 1'b0;
            if (is_alu(c) && alu_n >= ALU_MAX)                      ok = 1'b0;
            if ((is_alu(c) || is_lsu(c)) && mem_n >= INTMEM_MAX)    ok = 1'b0;
            if (c == C_INT_P0 && p0_n != 0)                         ok = 1'b0;
            if (c == C_INT_P1 && p1_n != 0)                         ok = 1'b0;
            if (is_lsu(c) && ls_n != 0)                             ok = 1'b0;
            if (c == C_CTI && cti_n != 0)                           ok = 1'b0;
            if (c == C_FPM && fpm_n != 0)                           ok = 1'b0;
            if (is_fpa(c) && fpa_n != 0)                            ok = 1'b0;
            if (c == C_FSENS && fsens_block)                        ok = 1'b0;
            accept[i] = ok;
            if (ok) begin
                n++;
                if (is_alu(c))                 alu_n++;
                if (is_alu(c) || is_lsu(c))    mem_n++;
                if (c == C_INT_P0)             p0_n++;
                if (c == C_INT_P1)             p1_n++;
                if (is_lsu(c))                 ls_n++;
                if (c == C_CTI)                cti_n++;
                if (c == C_FPM)                fpm_n++;
                if (is_fpa(c))                 fpa_n++;
                if (c == C_FCMP)               fc = 1'b1;
                if (ends_group(c))             open = 1'b0;
            end else begin
                open = 1'b0;
            end
        end
        size        = SZW'(n);
        fcmp_issued = fc;
    end

    logic [LANES-1:0] ls_mask;
    logic [LANES-1:0] brk_mask;
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign ls_mask[g]  = accept[g] && is_lsu(iclass_e'(cls[4*g +: 4]));
        assign brk_mask[g] = accept[g] && ends_group(iclass_e'(cls[4*g +: 4]));
    end

    assert_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((accept + 1'b1) & accept) == '0);

    assert_one_lsu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ls_mask) <= 1);

    assert_single_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept[0] && is_single(iclass_e'(cls[3:0]))) |-> (size == SZW'(1)));

    assert_break_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(brk_mask) <= 1);

endmodule

// File: rtl/unit_assigner.sv
module unit_assigner
    import gdisp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   accept,
    input  logic [4*LANES-1:0] cls,
    output logic [3*LANES-1:0] lane_unit
);

    always_comb begin
        logic has_p0, has_p1;
        int any_n;
        iclass_e c;
        unit_e u;
        has_p0 = 1'b0;
        has_p1 = 1'b0;
        any_n  = 0;
        for (int i = 0; i < LANES; i++) begin
            c = iclass_e'(cls[4*i +: 4]);
            if (accept[i] && c == C_INT_P0) has_p0 = 1'b1;
            if (accept[i] && c == C_INT_P1) has_p1 = 1'b1;
        end
        lane_unit = '0;
        for (int i = 0; i < LANES; i++) begin
            c = iclass_e'(cls[4*i +: 4]);
            u = U_NONE;
            if (accept[i]) begin
                unique case (c)
                    C_INT_ANY: begin
                        if (has_p0)          u = U_ALU1;
                        else if (has_p1)     u = U_ALU0;
                        else if (any_n == 0) u = U_ALU0;
                        else                 u = U_ALU1;
                        any_n++;
                    end
                    C_INT_P0:                     u = U_ALU0;
                    C_INT_P1:                     u = U_ALU1;
                    C_LOAD, C_STORE:              u = U_LSU;
                    C_CTI:                        u = U_BRU;
                    C_FPM:                        u = U_FPM;
                    C_FPA, C_FCMP, C_FSENS:       u = U_FPA;
                    C_JLINK:                      u = U_JLS;
                    default:                      u = U_ALU0;
                endcase
            end
            lane_unit[3*i +: 3] = u;
        end
    end

    logic [LANES-1:0] alu0_mask;
    logic [LANES-1:0] alu1_mask;
    for (genvar g = 0; g < LANES; g++) begin : g_umask
        assign alu0_mask[g] = (lane_unit[3*g +: 3] == U_ALU0);
        assign alu1_mask[g] = (lane_unit[3*g +: 3] == U_ALU1);
    end

    assert_alu0_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alu0_mask) <= 1);

    assert_alu1_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alu1_mask) <= 1);

endmodule

// File: rtl/stall_fsm.sv
module stall_fsm
    import gdisp_pkg::*;
#(
    parameter int DIV_BUB    = 68,
    parameter int MUL_BUB    = 19,
    parameter int CCRW_BUB   = 4,
    parameter int CCRR_BLOCK = 5,
    parameter int FCMP_WIN   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead_issue,
    input  logic [3:0] lead_cls,
    input  logic       fcmp_issued,
    output logic       issue_ok,
    output logic       fsens_block
);

    localparam int CCRR_BUB = CCRR_BLOCK - 1;
    localparam int MAX_A    = (DIV_BUB > MUL_BUB) ? DIV_BUB : MUL_BUB;
    localparam int MAX_B    = (CCRW_BUB > CCRR_BUB) ? CCRW_BUB : CCRR_BUB;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL  = (MAX_C > FCMP_WIN) ? MAX_C : FCMP_WIN;
    localparam int CW       = $clog2(MAX_ALL + 1);

    disp_state_e      state, state_nx;
    logic [CW-1:0]    cnt, cnt_nx;
    logic [CW-1:0]    bub;

    always_comb begin
        bub = '0;
        if (lead_issue) begin
            unique case (iclass_e'(lead_cls))
                C_DIV:    bub = CW'(DIV_BUB);
                C_MUL:    bub = CW'(MUL_BUB);
                C_CCR_WR: bub = CW'(CCRW_BUB);
                C_CCR_RD: bub = CW'(CCRR_BUB);
                default:  bub = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = ST_RUN;
        cnt_nx   = '0;
        unique case (state)
            ST_RUN, ST_FWIN: begin
                if (bub != '0) begin
                    state_nx = ST_STALL;
                    cnt_nx   = bub;
                end else if (fcmp_issued) begin
                    state_nx = ST_FWIN;
                    cnt_nx   = CW'(FCMP_WIN);
                end else if (state == ST_FWIN && cnt > CW'(1)) begin
                    state_nx = ST_FWIN;
                    cnt_nx   = cnt - 1'b1;
                end
            end
            ST_STALL: begin
                if (cnt > CW'(1)) begin
                    state_nx = ST_STALL;
                    cnt_nx   = cnt - 1'b1;
                end
            end
            default: begin
                state_nx = ST_RUN;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        issue_ok    = (state != ST_STALL);
        fsens_block = (state == ST_FWIN);
    end

    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> !lead_issue);

    assert_bubble_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STALL && bub != '0) |=> (state == ST_STALL && cnt == $past(bub)));

    assert_fsens_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fsens_block |-> !(lead_issue && lead_cls == C_FSENS));

    assert_window_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STALL && bub == '0 && fcmp_issued) |=> (state == ST_FWIN));

endmodule

// File: rtl/group_dispatch4.sv
module group_dispatch4
    import gdisp_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ALU_MAX    = 2,
    parameter int INTMEM_MAX = 3,
    parameter int DIV_BUB    = 68,
    parameter int MUL_BUB    = 19,
    parameter int CCRW_BUB   = 4,
    parameter int CCRR_BLOCK = 5,
    parameter int FCMP_WIN   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              head_vld,
    input  logic [4*LANES-1:0]            head_cls,
    output logic [$clog2(LANES+1)-1:0]    grp_size,
    output logic [3*LANES-1:0]            lane_unit
);

    localparam int SZW = $clog2(LANES + 1);

    logic [LANES-1:0] accept;
    logic             issue_ok;
    logic             fsens_block;
    logic             fcmp_issued;

    grp_former #(
        .LANES      (LANES),
        .ALU_MAX    (ALU_MAX),
        .INTMEM_MAX (INTMEM_MAX),
        .SZW        (SZW)
    ) u_form (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld         (head_vld),
        .cls         (head_cls),
        .issue_ok    (issue_ok),
        .fsens_block (fsens_block),
        .accept      (accept),
        .size        (grp_size),
        .fcmp_issued (fcmp_issued)
    );

    unit_assigner #(
        .LANES (LANES)
    ) u_assign (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cls       (head_cls),
        .lane_unit (lane_unit)
    );

    stall_fsm #(
        .DIV_BUB    (DIV_BUB),
        .MUL_BUB    (MUL_BUB),
        .CCRW_BUB   (CCRW_BUB),
        .CCRR_BLOCK (CCRR_BLOCK),
        .FCMP_WIN   (FCMP_WIN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lead_issue  (accept[0]),
        .lead_cls    (head_cls[3:0]),
        .fcmp_issued (fcmp_issued),
        .issue_ok    (issue_ok),
        .fsens_block (fsens_block)
    );

endmodule

// File: tb/group_dispatch4_tb.sv
`timescale 1ns/1ps
module group_dispatch4_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  head_vld = '0;
    logic [15:0] head_cls = '0;
    logic [2:0]  grp_size;
    logic [11:0] lane_unit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    group_dispatch4 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_vld  (head_vld),
        .head_cls  (head_cls),
        .grp_size  (grp_size),
        .lane_unit (lane_unit)
    );

    // {vld, cls (lane3..lane0 hex), size, units (lane3..lane0 octal)}
    localparam int NV = 16;
    localparam logic [34:0] VEC [NV] = '{
        {4'hF,    16'h5030, 3'd4, 12'o4231},  // R1 R2 full group
        {4'hF,    16'h0033, 3'd1, 12'o0003},  // R3 two loads
        {4'hF,    16'h0094, 3'd1, 12'o0003},  // R3 store + jump-link
        {4'hF,    16'h7000, 3'd2, 12'o0021},  // R5 three ALU ops
        {4'hF,    16'h0011, 3'd1, 12'o0001},  // R5 two pipe-0
        {4'hF,    16'h7610, 3'd4, 12'o6512},  // R6 any moves to ALU1
        {4'hF,    16'h5502, 3'd3, 12'o0412},  // R4 R6 two CTIs, any to ALU0
        {4'hF,    16'h0066, 3'd1, 12'o0005},  // R4 two FP mul
        {4'hF,    16'h0765, 3'd3, 12'o0654},  // R2 int at position 3
        {4'hF,    16'h0080, 3'd1, 12'o0001},  // R7 single at lane1
        {4'hF,    16'h0008, 3'd1, 12'o0001},  // R7 single at lane0
        {4'hF,    16'h0009, 3'd1, 12'o0007},  // R8 jump-link first
        {4'b1101, 16'h0000, 3'd1, 12'o0001},  // R1 invalid lane1
        {4'h0,    16'h0000, 3'd0, 12'o0000},  // R1 nothing valid
        {4'hF,    16'h0590, 3'd2, 12'o0071},  // R8 jump-link ends group
        {4'hF,    16'h00F7, 3'd1, 12'o0006}   // R4 FP add + sensitive
    };

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic bub_run(input logic [3:0] c, input int exp, input string req);
        int zeros;
        @(negedge clk);
        head_vld = 4'b0001;
        head_cls = {12'h000, c};
        #1;
        chk(grp_size == 3'd1, req, int'(grp_size), 1);
        @(negedge clk);
        head_cls = 16'h0000;
        #1;
        zeros = 0;
        while (grp_size == 3'd0 && zeros < 300) begin
            zeros++;
            @(negedge clk);
            #1;
        end
        chk(zeros == exp, req, zeros, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R12: reset state, plain grouping during reset
        head_vld = 4'hF;
        head_cls = 16'h5030;
        #2;
        chk(grp_size == 3'd4, "R12", int'(grp_size), 4);
        chk(lane_unit == 12'o4231, "R12", int'(lane_unit), 12'o4231);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            head_vld = VEC[k][34:31];
            head_cls = VEC[k][30:15];
            #1;
            chk(grp_size == VEC[k][14:12], $sformatf("R1-table size vec%0d", k),
                int'(grp_size), int'(VEC[k][14:12]));
            chk(lane_unit == VEC[k][11:0], $sformatf("R6-table units vec%0d", k),
                int'(lane_unit), int'(VEC[k][11:0]));
        end

        bub_run(4'd10, 68, "R9 divide bubbles");
        bub_run(4'd11, 19, "R9 multiply bubbles");
        bub_run(4'd12, 4,  "R9 cc-write bubbles");
        bub_run(4'd13, 4,  "R10 cc-read block");

        // R11: FP compare window
        @(negedge clk);
        head_vld = 4'b0001;
        head_cls = 16'h000E;
        #1;
        chk(grp_size == 3'd1, "R11 fcmp issue", int'(grp_size), 1);
        chk(lane_unit == 12'o0006, "R11 fcmp unit", int'(lane_unit), 12'o0006);
        @(negedge clk);
        head_vld = 4'b0011;
        head_cls = 16'h00F0;
        #1;
        chk(grp_size == 3'd1, "R11 window cycle1", int'(grp_size), 1);
        chk(lane_unit == 12'o0001, "R11 window cycle1 units", int'(lane_unit), 12'o0001);
        @(negedge clk);
        head_vld = 4'b0001;
        head_cls = 16'h000F;
        #1;
        chk(grp_size == 3'd0, "R11 window cycle2", int'(grp_size), 0);
        @(negedge clk);
        #1;
        chk(grp_size == 3'd1, "R11 window closed", int'(grp_size), 1);
        chk(lane_unit == 12'o0006, "R11 window closed unit", int'(lane_unit), 12'o0006);

        // R12: reset in the middle of a stall
        @(negedge clk);
        head_vld = 4'b0001;
        head_cls = 16'h000A;
        @(negedge clk);
        head_cls = 16'h0000;
        #1;
        chk(grp_size == 3'd0, "R12 stall before reset", int'(grp_size), 0);
        rst_n = 1'b0;
        #1;
        chk(grp_size == 3'd1, "R12 reset clears stall", int'(grp_size), 1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(grp_size == 3'd1, "R12 after reset", int'(grp_size), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule